// File: doc/BRIEF.md
# Vector Shift-Left-and-Insert Unit

This block executes one vector shift-left-and-insert operation on a 128-bit vector. A caller presents a 32-bit instruction word together with a source vector and the present contents of the destination vector, and raises a request strobe. The unit confirms that the word carries this operation's fixed opcode bits. It then decodes the element width and the shift distance from a single packed 7-bit immediate field.

Every element of the source is shifted left by that distance. The shifted element is merged into the matching destination element. Destination bits below the shift point are kept, and every bit at or above it is taken from the shifted source. All elements are processed; there is no predication. The merged vector and two status flags appear one clock after the request.

The status flags cover two cases. One reports a word that is not this operation. The other reports a word whose size code is zero, which is undefined. In either case the returned vector equals the destination unchanged. The register-select fields of the word are carried but play no part in the arithmetic, since the register file lives outside this block.

Top module: `vsli_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high, and is low otherwise; a synchronous active-high `rst` forces `out_valid`, `out_undef` and `out_nomatch` low.
- R2: A word is recognised only when `instr[31:24]` = 8'h45, `instr[21]` = 0 and `instr[15:10]` = 6'b111101. Otherwise, at the response `out_nomatch` = 1, `out_undef` = 0 and `out_vec` equals the destination vector supplied with the request.
- R3: The size code is {`instr[23:22]`, `instr[20:19]`}. For a recognised word with size code 0000, the response has `out_undef` = 1 and `out_nomatch` = 0, and `out_vec` equals the supplied destination vector.
- R4: Element width is 8 shifted left by the position of the highest set bit of the size code, giving 8, 16, 32 or 64. The shift equals the unsigned value of {size code, `instr[18:16]`} minus the width.
- R5: For a recognised, defined word, each element result is (dst AND NOT mask) OR (src << shift), where mask = all-ones << shift. Element k occupies bits [k*W+W-1 : k*W]. Every element of the 128-bit vector is processed, and both flags are 0.
- R6: A shift of 0 makes every result element an exact copy of the source element.
- R7: A shift of W-1 places source bit 0 of each element in that element's top bit and keeps the lower W-1 destination bits.
- R8: The register-select fields `instr[9:5]` and `instr[4:0]` have no effect on `out_vec` or on either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are taken on this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Current destination vector |
| out_valid | output | 1 | Response strobe, one cycle after the request |
| out_vec | output | 128 | New destination vector |
| out_undef | output | 1 | Recognised word with a zero size code |
| out_nomatch | output | 1 | Word lacks the fixed opcode bits |

## Verification
The bound checker watches the handshake on every cycle. It checks that a response follows each request by exactly one clock and that no response appears without one. It also checks that the two flags never rise together or outside a response, that each flag agrees with the opcode and size-code bits of the word sent a cycle earlier, and that a flagged response returns the earlier destination untouched. The arithmetic itself is exercised only by the bench's scenarios. These compare every element width, including shifts of zero and width minus one, against a bit-by-bit model, and also drive back-to-back requests and words that differ only in their register fields.

// File: rtl/vsli_pkg.sv
package vsli_pkg;
   localparam int INSTR_W     = 32;
   localparam int SIZE_CODE_W = 4;
   localparam int IMM_W       = 3;
   localparam int FIELD_W     = SIZE_CODE_W + IMM_W;
   localparam int SHIFT_W     = 6;
   localparam int NUM_SIZES   = 4;
   localparam int ELEM_MIN    = 8;
   localparam int ELEM_MAX    = ELEM_MIN << (NUM_SIZES - 1);
   localparam int IDX_W       = $clog2(NUM_SIZES);

   localparam logic [7:0] OPC_HI  = 8'h45;
   localparam logic [5:0] OPC_LO  = 6'b111101;

   typedef struct packed {
      logic               match;
      logic               undef;
      logic [IDX_W-1:0]   size_idx;
      logic [SHIFT_W-1:0] shamt;
   } dec_t;

   // Position of the highest set bit of a size code (0 when code is 0).
   function automatic logic [IDX_W-1:0] top_bit_index(input logic [SIZE_CODE_W-1:0] code);
      logic [IDX_W-1:0] idx;
      idx = '0;
      for (int b = 0; b < SIZE_CODE_W; b++) begin
         if (code[b]) idx = IDX_W'(b);
      end
      return idx;
   endfunction
endpackage

// File: rtl/vsli_decode.sv
module vsli_decode
   import vsli_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);
   logic [SIZE_CODE_W-1:0] size_code;
   logic [IMM_W-1:0]       imm_lo;
   logic [FIELD_W-1:0]     packed_field;
   logic [FIELD_W-1:0]     elem_bits;
   logic [FIELD_W-1:0]     diff;
   logic                   unused_regsel;

   assign size_code     = {instr[23:22], instr[20:19]};
   assign imm_lo        = instr[18:16];
   assign packed_field  = {size_code, imm_lo};
   assign unused_regsel = ^instr[9:0];

   always_comb begin
      dec.match    = (instr[31:24] == OPC_HI) && (instr[21] == 1'b0) &&
                     (instr[15:10] == OPC_LO);
      dec.undef    = dec.match && (size_code == '0);
      dec.size_idx = top_bit_index(size_code);
      elem_bits    = FIELD_W'(ELEM_MIN) << dec.size_idx;
      diff         = packed_field - elem_bits;
      dec.shamt    = SHIFT_W'(diff);
   end
endmodule

// File: rtl/vsli_lane.sv
module vsli_lane
   import vsli_pkg::*;
#(
   parameter int EW = 8
) (
   input  logic [EW-1:0]      src,
   input  logic [EW-1:0]      dst,
   input  logic [SHIFT_W-1:0] shamt,
   output logic [EW-1:0]      res
);
   logic [EW-1:0] keep_mask;
   logic [EW-1:0] moved;

   if (EW < 1 || EW > (1 << SHIFT_W)) begin : g_bad_ew
      $error("vsli_lane: EW out of range");
   end

   always_comb begin
      keep_mask = {EW{1'b1}} << shamt;
      moved     = src << shamt;
      res       = (dst & ~keep_mask) | moved;
   end
endmodule

// File: rtl/vsli_merge_array.sv
module vsli_merge_array
   import vsli_pkg::*;
#(
   parameter int VLEN = 128
) (
   input  logic [VLEN-1:0]    src,
   input  logic [VLEN-1:0]    dst,
   input  logic [IDX_W-1:0]   size_idx,
   input  logic [SHIFT_W-1:0] shamt,
   output logic [VLEN-1:0]    merged
);
   logic [VLEN-1:0] cand [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int EW = ELEM_MIN << g;
      localparam int NE = VLEN / EW;
      for (genvar e = 0; e < NE; e++) begin : g_elem
         vsli_lane #(.EW(EW)) lane_i (
            .src   (src[e*EW +: EW]),
            .dst   (dst[e*EW +: EW]),
            .shamt (shamt),
            .res   (cand[g][e*EW +: EW])
         );
      end
   end

   assign merged = cand[size_idx];
endmodule

// File: rtl/vsli_unit.sv
module vsli_unit
   import vsli_pkg::*;
#(
   parameter int VLEN = 128
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [31:0]        instr,
   input  logic [VLEN-1:0]    src_vec,
   input  logic [VLEN-1:0]    dst_vec,
   output logic               out_valid,
   output logic [VLEN-1:0]    out_vec,
   output logic               out_undef,
   output logic               out_nomatch
);
   if (VLEN < ELEM_MAX || (VLEN % ELEM_MAX) != 0) begin : g_bad_vlen
      $error("vsli_unit: VLEN must be a multiple of the widest element");
   end
   if (INSTR_W != 32) begin : g_bad_instr
      $error("vsli_unit: instruction width must be 32");
   end

   dec_t            dec;
   logic [VLEN-1:0] merged;
   logic            take_result;

   vsli_decode dec_i (
      .instr (instr),
      .dec   (dec)
   );

   vsli_merge_array #(.VLEN(VLEN)) merge_i (
      .src      (src_vec),
      .dst      (dst_vec),
      .size_idx (dec.size_idx),
      .shamt    (dec.shamt),
      .merged   (merged)
   );

   assign take_result = dec.match && !dec.undef;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_undef   <= 1'b0;
         out_nomatch <= 1'b0;
         out_vec     <= '0;
      end else begin
         out_valid   <= in_valid;
         out_undef   <= in_valid && dec.undef;
         out_nomatch <= in_valid && !dec.match;
         if (in_valid) begin
            out_vec <= take_result ? merged : dst_vec;
         end
      end
   end
endmodule

// File: rtl/vsli_unit_chk.sv
module vsli_unit_chk #(
   parameter int VLEN = 128
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic [31:0]     instr,
   input logic [VLEN-1:0] dst_vec,
   input logic            out_valid,
   input logic [VLEN-1:0] out_vec,
   input logic            out_undef,
   input logic            out_nomatch
);
   // R1
   resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   // R1
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && !out_undef && !out_nomatch));
   // R2
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(out_undef && out_nomatch));
   // R2
   flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!out_undef && !out_nomatch));
   // R2
   nomatch_tracks_opcode_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_nomatch == !(($past(instr[31:24]) == 8'h45) &&
                                     ($past(instr[21]) == 1'b0) &&
                                     ($past(instr[15:10]) == 6'b111101))));
   // R3
   undef_tracks_size_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[31:24] == 8'h45 && !instr[21] && instr[15:10] == 6'b111101)
      |=> (out_undef == ($past(instr[23:22]) == 2'b00 && $past(instr[20:19]) == 2'b00)));
   // R3
   flagged_keeps_dst_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ((out_undef || out_nomatch) -> (out_vec == $past(dst_vec))));
endmodule

bind vsli_unit vsli_unit_chk #(.VLEN(VLEN)) chk_i (.*);

// File: tb/vsli_unit_tb_top.sv
`timescale 1ns/1ps
module vsli_unit_tb_top;
   localparam int VL = 128;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [31:0]   instr;
   logic [VL-1:0] src_vec, dst_vec;
   logic          out_valid, out_undef, out_nomatch;
   logic [VL-1:0] out_vec;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   vsli_unit #(.VLEN(VL)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
      .src_vec(src_vec), .dst_vec(dst_vec), .out_valid(out_valid),
      .out_vec(out_vec), .out_undef(out_undef), .out_nomatch(out_nomatch)
   );

   function automatic logic [VL-1:0] rnd_vec();
      logic [VL-1:0] v;
      for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // Bit-by-bit model of the merge.
   function automatic logic [VL-1:0] model(input logic [VL-1:0] s, d, input int w, sh);
      logic [VL-1:0] r;
      for (int i = 0; i < VL; i++) begin
         int pos = i % w;
         r[i] = (pos < sh) ? d[i] : s[i - sh];
      end
      return r;
   endfunction

   function automatic logic [31:0] mk(input int w, sh, input logic [4:0] zn, zd);
      logic [6:0] f;
      f = 7'(w + sh);
      return {8'h45, f[6:5], 1'b0, f[4:3], f[2:0], 5'b11110, 1'b1, zn, zd};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [VL-1:0] act, input logic [VL-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_resp(input logic [VL-1:0] ev, input logic eu, en, input string req);
      chk(out_valid === 1'b1, req, "valid", VL'(out_valid), VL'(1));
      chk(out_vec === ev, req, "vec", out_vec, ev);
      chk(out_undef === eu, req, "undef", VL'(out_undef), VL'(eu));
      chk(out_nomatch === en, req, "nomatch", VL'(out_nomatch), VL'(en));
   endtask

   task automatic send_and_check(input logic [31:0] ins, input logic [VL-1:0] s, d,
                                 input logic [VL-1:0] ev, input logic eu, en,
                                 input string req);
      @(negedge clk);
      in_valid = 1'b1; instr = ins; src_vec = s; dst_vec = d;
      @(negedge clk);
      in_valid = 1'b0; dst_vec = rnd_vec(); src_vec = rnd_vec();
      check_resp(ev, eu, en, req);
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b0; instr = '0; src_vec = '0; dst_vec = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid === 1'b0, "R1", "reset valid", VL'(out_valid), '0);
      chk(out_undef === 1'b0 && out_nomatch === 1'b0, "R1", "reset flags",
          VL'({out_undef, out_nomatch}), '0);
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid === 1'b0, "R1", "idle after reset", VL'(out_valid), '0);
   endtask

   task automatic t_width(input int w);
      int sh_list[4];
      sh_list = '{0, w - 1, w / 2, 1};
      foreach (sh_list[k]) begin
         logic [VL-1:0] s = rnd_vec();
         logic [VL-1:0] d = rnd_vec();
         int sh = sh_list[k];
         string tag = (sh == 0) ? "R6" : ((sh == w - 1) ? "R7" : "R5");
         send_and_check(mk(w, sh, 5'd3, 5'd7), s, d, model(s, d, w, sh), 1'b0, 1'b0, tag);
         // R4: the word encodes this width and shift
         if (sh == 0) chk(out_vec === s, "R4", "shift0 copy", out_vec, s);
      end
   endtask

   task automatic t_patterns();
      // R5: all-ones source into zero destination, 16-bit, shift 4
      send_and_check(mk(16, 4, 5'd0, 5'd0), '1, '0, {8{16'hFFF0}}, 1'b0, 1'b0, "R5");
      // R7: 8-bit lanes, shift 7, src 0x01 per lane, dst 0x00
      send_and_check(mk(8, 7, 5'd1, 5'd2), {16{8'h01}}, '0, {16{8'h80}}, 1'b0, 1'b0, "R7");
      // R4: 64-bit width, shift 32, distinguish halves
      send_and_check(mk(64, 32, 5'd9, 5'd9), {2{64'h0000_0000_DEAD_BEEF}},
                     {2{64'h1111_2222_3333_4444}}, {2{64'hDEAD_BEEF_3333_4444}},
                     1'b0, 1'b0, "R4");
   endtask

   task automatic t_undef();
      logic [VL-1:0] d = rnd_vec();
      // R3: size code 0000 with nonzero imm3
      send_and_check({8'h45, 2'b00, 1'b0, 2'b00, 3'b101, 6'b111101, 5'd4, 5'd5},
                     rnd_vec(), d, d, 1'b1, 1'b0, "R3");
   endtask

   task automatic t_nomatch();
      logic [31:0] good = mk(32, 5, 5'd1, 5'd1);
      int flips[3] = '{21, 10, 28};
      foreach (flips[k]) begin
         logic [VL-1:0] d = rnd_vec();
         logic [31:0] bad = good;
         bad[flips[k]] = ~bad[flips[k]];
         send_and_check(bad, rnd_vec(), d, d, 1'b0, 1'b1, "R2");
      end
   endtask

   task automatic t_regfields();
      logic [VL-1:0] s = rnd_vec();
      logic [VL-1:0] d = rnd_vec();
      // R8: same data, register fields at extremes
      send_and_check(mk(16, 9, 5'd0, 5'd0), s, d, model(s, d, 16, 9), 1'b0, 1'b0, "R8");
      send_and_check(mk(16, 9, 5'd31, 5'd31), s, d, model(s, d, 16, 9), 1'b0, 1'b0, "R8");
   endtask

   task automatic t_stream();
      logic [VL-1:0] s1 = rnd_vec(), d1 = rnd_vec(), s2 = rnd_vec(), d2 = rnd_vec();
      @(negedge clk);
      in_valid = 1'b1; instr = mk(8, 3, 5'd1, 5'd2); src_vec = s1; dst_vec = d1;
      @(negedge clk);
      instr = mk(32, 31, 5'd1, 5'd2); src_vec = s2; dst_vec = d2;
      check_resp(model(s1, d1, 8, 3), 1'b0, 1'b0, "R1");
      @(negedge clk);
      in_valid = 1'b0;
      check_resp(model(s2, d2, 32, 31), 1'b0, 1'b0, "R1");
      @(negedge clk);
      // R1: no response without a request
      chk(out_valid === 1'b0, "R1", "idle valid", VL'(out_valid), '0);
   endtask

   initial begin
      t_reset();
      t_width(8);
      t_width(16);
      t_width(32);
      t_width(64);
      t_patterns();
      t_undef();
      t_nomatch();
      t_regfields();
      t_stream();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule